// File: doc/BRIEF.md
# Byte-Lane Static Memory with Dual Chip Selects

This block is a synthesizable functional model of an asynchronous static memory holding 16-bit words. The depth is a parameter. Six control inputs drive it: two chip selects of opposite polarity, an active-low output enable, an active-low write enable and two active-low byte-lane enables. The model decodes these inputs into one of four modes: standby, outputs disabled, read and write. Read data and write data use separate ports. A per-lane drive indication stands in for the tri-state drivers of a real memory pin.

A clock samples the control inputs. A write is held pending for as long as the write condition stays true. It is committed on the first clock edge at which the condition has gone false. The commit uses the address, data and lane selection captured at the edge before. A write therefore ends at whichever comes first: write enable rising, either select going inactive, or both lane enables going inactive. Reads are combinational from the address and show the committed array contents. Lanes that are not driven read as zero. Status outputs show whether the device is in standby or active.

Top module: `sram16_dual_sel`

## Requirements
- R1: The device is in standby whenever `cs_n` is 1, `cs_hi` is 0, or both `lb_n` and `ub_n` are 1. In standby, `standby`=1, `active`=0, `rd_lane_en`=2'b00 and `rdata`=0.
- R2: In every case not covered by R1, `standby`=0 and `active`=1.
- R3: With `cs_n`=0, `cs_hi`=1, `oe_n`=0 and `we_n`=1, bit 0 of `rd_lane_en` is the inverse of `lb_n` and bit 1 is the inverse of `ub_n`. Each driven lane shows the stored bits at `addr`: `lb_n` controls bits 7..0 and `ub_n` controls bits 15..8. A lane that is not driven reads as zero.
- R4: With both selects active and both `oe_n` and `we_n` at 1, `rd_lane_en`=2'b00 and `rdata`=0, while `active` stays 1.
- R5: While `we_n`=0, `rd_lane_en` is 2'b00 whatever the value of `oe_n`.
- R6: The write condition is `cs_n`=0, `cs_hi`=1, `we_n`=0 and at least one lane enable at 0. A write is committed at the first rising clock edge at which this condition is false after being true at the previous edge. After that edge, a read of the written address returns the new data.
- R7: A write updates only the lanes whose enable was 0 at the last edge of the write. The other lane keeps its old contents.
- R8: A write also ends, and commits, when `cs_n` rises or `cs_hi` falls while `we_n` is still 0.
- R9: When the address or data changes while a write is held, only the values sampled at the last edge where the write condition was true are stored. Earlier values leave no trace in the array.
- R10: A write condition that is active while `rst_n`=0, and ends during reset, commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the write tracker |
| rst_n | input | 1 | Active-low asynchronous reset of the write tracker |
| cs_n | input | 1 | Chip select, active low |
| cs_hi | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| lb_n | input | 1 | Lower lane (bits 7..0) enable, active low |
| ub_n | input | 1 | Upper lane (bits 15..8) enable, active low |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, zero on lanes not driven |
| rd_lane_en | output | 2 | Per-lane drive indication (bit 0 lower, bit 1 upper) |
| standby | output | 1 | Device deselected |
| active | output | 1 | Device selected |

## Verification
A stale or corrupted pending-write register shows up on the first read of the affected address after the write ends. That read happens one clock edge after the commit. The symptom is a wrong byte in one lane, or a word stored at an address used earlier in the write. A decode error is visible at once, with no clock delay, on `rd_lane_en`, `standby` and `active`. For this reason every random read also checks the lane enables. Before any read is made, the whole array is written with known words, so that a misdirected byte write is detected at the next read of either address involved.

// File: rtl/sram16_pkg.sv
package sram16_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_OUT_OFF = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;

  // Deselected when either select is inactive or no lane is enabled.
  function automatic logic is_deselected(input logic cs_n, input logic cs_hi,
                                         input logic [LANES-1:0] lane_n);
    return cs_n | ~cs_hi | (&lane_n);
  endfunction

  // Mode decode: write wins over output enable once selected.
  function automatic sram_mode_e decode_mode(input logic cs_n, input logic cs_hi,
                                             input logic oe_n, input logic we_n,
                                             input logic [LANES-1:0] lane_n);
    if (is_deselected(cs_n, cs_hi, lane_n)) return MODE_STANDBY;
    if (!we_n)                              return MODE_WRITE;
    if (!oe_n)                              return MODE_READ;
    return MODE_OUT_OFF;
  endfunction

  // Expand a per-lane enable vector to a bit mask over the word.
  function automatic logic [WORD_W-1:0] lane_mask(input logic [LANES-1:0] en);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{en[i]}};
    return m;
  endfunction

endpackage

// File: rtl/sram16_ctrl_decode.sv
module sram16_ctrl_decode
  import sram16_pkg::*;
(
  input  logic             cs_n,
  input  logic             cs_hi,
  input  logic             oe_n,
  input  logic             we_n,
  input  logic [LANES-1:0] lane_n,
  output sram_mode_e       mode,
  output logic [LANES-1:0] lane_sel,
  output logic [LANES-1:0] drive_en,
  output logic             wr_cond
);

  always_comb begin
    mode     = decode_mode(cs_n, cs_hi, oe_n, we_n, lane_n);
    lane_sel = ~lane_n;
    wr_cond  = (mode == MODE_WRITE);
    drive_en = (mode == MODE_READ) ? lane_sel : '0;
  end

endmodule

// File: rtl/sram16_write_tracker.sv
module sram16_write_tracker
  import sram16_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cond,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_sel,
  output logic              commit,
  output logic [AW-1:0]     cmt_addr,
  output logic [WORD_W-1:0] cmt_data,
  output logic [LANES-1:0]  cmt_lanes
);

  logic wr_cond_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cond_q <= 1'b0;
      cmt_addr  <= '0;
      cmt_data  <= '0;
      cmt_lanes <= '0;
    end else begin
      wr_cond_q <= wr_cond;
      if (wr_cond) begin
        cmt_addr  <= addr;
        cmt_data  <= wdata;
        cmt_lanes <= lane_sel;
      end
    end
  end

  // End of write: condition held at the previous edge, gone now.
  assign commit = wr_cond_q & ~wr_cond;

  // R6
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ($past(wr_cond) && !wr_cond));

  // R6
  commit_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R7
  commit_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (cmt_lanes != '0));

endmodule

// File: rtl/sram16_array.sv
module sram16_array
  import sram16_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              commit,
  input  logic [AW-1:0]     cmt_addr,
  input  logic [WORD_W-1:0] cmt_data,
  input  logic [LANES-1:0]  cmt_lanes,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (commit && cmt_lanes[g]) mem[cmt_addr] <= cmt_data[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sram16_dual_sel.sv
module sram16_dual_sel
  import sram16_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs_hi,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [LANES-1:0]  rd_lane_en,
  output logic              standby,
  output logic              active
);

  sram_mode_e        mode;
  logic [LANES-1:0]  lane_sel;
  logic [LANES-1:0]  drive_en;
  logic              wr_cond;
  logic              commit;
  logic [AW-1:0]     cmt_addr;
  logic [WORD_W-1:0] cmt_data;
  logic [LANES-1:0]  cmt_lanes;
  logic [WORD_W-1:0] rd_word;

  sram16_ctrl_decode u_decode (
    .cs_n     (cs_n),
    .cs_hi    (cs_hi),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .lane_n   ({ub_n, lb_n}),
    .mode     (mode),
    .lane_sel (lane_sel),
    .drive_en (drive_en),
    .wr_cond  (wr_cond)
  );

  sram16_write_tracker #(.AW(AW)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_cond   (wr_cond),
    .addr      (addr),
    .wdata     (wdata),
    .lane_sel  (lane_sel),
    .commit    (commit),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data),
    .cmt_lanes (cmt_lanes)
  );

  sram16_array #(.DEPTH(DEPTH)) u_array (
    .clk       (clk),
    .commit    (commit),
    .cmt_addr  (cmt_addr),
    .cmt_data  (cmt_data),
    .cmt_lanes (cmt_lanes),
    .rd_addr   (addr),
    .rd_word   (rd_word)
  );

  assign standby    = (mode == MODE_STANDBY);
  assign active     = ~standby;
  assign rd_lane_en = drive_en;
  assign rdata      = rd_word & lane_mask(drive_en);

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || !cs_hi || (lb_n && ub_n)) |-> (standby && rd_lane_en == '0 && rdata == '0));

  // R5
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (rd_lane_en == '0));

  // R3
  read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_hi && !oe_n && we_n) |-> (rd_lane_en == {~ub_n, ~lb_n}));

  // R4
  out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && cs_hi && oe_n && we_n && !(lb_n && ub_n)) |-> (active && rdata == '0));

endmodule

// File: tb/sram16_dual_sel_bench.sv
module sram16_dual_sel_bench;

  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, cs_hi = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic          lb_n = 1'b1, ub_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [1:0]    rd_lane_en;
  logic          standby, active;

  logic [15:0]   ref_mem [DEPTH];
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            finished = 1'b0;

  always #5 clk = ~clk;

  sram16_dual_sel #(.DEPTH(DEPTH)) u_sram16_dual_sel (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .oe_n(oe_n),
    .we_n(we_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rd_lane_en(rd_lane_en), .standby(standby), .active(active)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input logic l_n, input logic u_n);
    logic [7:0] lo, hi;
    lo = l_n ? 8'h00 : ref_mem[a][7:0];
    hi = u_n ? 8'h00 : ref_mem[a][15:8];
    return {hi, lo};
  endfunction

  function automatic bit exp_standby(input logic c0, input logic c1, input logic l_n, input logic u_n);
    return (c0 == 1'b1) || (c1 == 1'b0) || (l_n && u_n);
  endfunction

  // Write with hold cycles; earlier hold cycles carry decoy addr/data.
  // style: 0 = we_n rises, 1 = cs_n rises, 2 = cs_hi falls
  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic l_n, input logic u_n, input int hold, input int style);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      cs_n = 1'b0; cs_hi = 1'b1; we_n = 1'b0; oe_n = 1'($urandom_range(1));
      lb_n = l_n; ub_n = u_n;
      addr  = (i == hold - 1) ? a : AW'($urandom);
      wdata = (i == hold - 1) ? d : 16'($urandom);
      #2;
      chk("R5 lanes off during write", {30'd0, rd_lane_en}, 32'd0);
    end
    @(negedge clk);
    case (style)
      0: we_n = 1'b1;
      1: cs_n = 1'b1;
      default: cs_hi = 1'b0;
    endcase
    if (!l_n) ref_mem[a][7:0]  = d[7:0];
    if (!u_n) ref_mem[a][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic l_n, input logic u_n,
                         input logic oe, input string tag);
    @(negedge clk);
    cs_n = 1'b0; cs_hi = 1'b1; we_n = 1'b1; oe_n = oe; lb_n = l_n; ub_n = u_n; addr = a;
    wdata = 16'($urandom);
    #2;
    if (oe) begin
      chk({tag, " R4 lanes"}, {30'd0, rd_lane_en}, 32'd0);
      chk({tag, " R4 data"}, {16'd0, rdata}, 32'd0);
    end else begin
      chk({tag, " R3 lanes"}, {30'd0, rd_lane_en}, {30'd0, ~u_n, ~l_n});
      chk({tag, " R3 data"}, {16'd0, rdata}, {16'd0, exp_read(a, l_n, u_n)});
    end
    chk({tag, " R2 active"}, {30'd0, standby, active},
        exp_standby(1'b0, 1'b1, l_n, u_n) ? 32'd2 : 32'd1);
  endtask

  task automatic do_standby(input logic c0, input logic c1, input logic l_n, input logic u_n);
    @(negedge clk);
    cs_n = c0; cs_hi = c1; lb_n = l_n; ub_n = u_n;
    oe_n = 1'($urandom_range(1)); we_n = 1'b1; addr = AW'($urandom);
    #2;
    chk("R1 status", {30'd0, standby, active}, 32'd2);
    chk("R1 lanes", {30'd0, rd_lane_en}, 32'd0);
    chk("R1 data", {16'd0, rdata}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0A17));
    // Reset state
    #2;
    chk("R1 reset standby", {30'd0, standby, active}, 32'd2);
    chk("R1 reset data", {16'd0, rdata}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Fill the array with known words
    for (int a = 0; a < DEPTH; a++) do_write(AW'(a), 16'($urandom), 1'b0, 1'b0, 1, 0);

    // Directed: byte writes keep the other lane (R7)
    do_write(8'h10, 16'hA55A, 1'b0, 1'b0, 1, 0);
    do_write(8'h10, 16'h1234, 1'b0, 1'b1, 1, 0);
    do_read(8'h10, 1'b0, 1'b0, 1'b0, "R7 lower only");
    chk("R7 word after lower write", {16'd0, rdata}, 32'h0000A534);
    do_write(8'h10, 16'hBEEF, 1'b1, 1'b0, 1, 0);
    do_read(8'h10, 1'b0, 1'b0, 1'b0, "R7 upper only");
    chk("R7 word after upper write", {16'd0, rdata}, 32'h0000BE34);

    // Directed: write ended by select changes (R8)
    do_write(8'h20, 16'hC0DE, 1'b0, 1'b0, 2, 1);
    do_read(8'h20, 1'b0, 1'b0, 1'b0, "R8 cs_n end");
    chk("R8 cs_n end word", {16'd0, rdata}, 32'h0000C0DE);
    do_write(8'h21, 16'hF00D, 1'b0, 1'b0, 2, 2);
    do_read(8'h21, 1'b0, 1'b0, 1'b0, "R8 cs_hi end");
    chk("R8 cs_hi end word", {16'd0, rdata}, 32'h0000F00D);

    // Directed: long hold with decoy addresses, last sample wins (R9)
    do_write(8'h30, 16'h7E57, 1'b0, 1'b0, 4, 0);
    do_read(8'h30, 1'b0, 1'b0, 1'b0, "R9 last sample");
    chk("R9 stored word", {16'd0, rdata}, 32'h00007E57);

    // Directed: standby corners (R1) and output-disabled (R4)
    do_standby(1'b1, 1'b1, 1'b0, 1'b0);
    do_standby(1'b0, 1'b0, 1'b0, 1'b0);
    do_standby(1'b0, 1'b1, 1'b1, 1'b1);
    do_read(8'h30, 1'b0, 1'b0, 1'b1, "R4 oe high");

    // Directed: write aborted by reset (R10)
    do_write(8'h40, 16'h1111, 1'b0, 1'b0, 1, 0);
    @(negedge clk);
    cs_n = 1'b0; cs_hi = 1'b1; we_n = 1'b0; lb_n = 1'b0; ub_n = 1'b0;
    addr = 8'h40; wdata = 16'h2222;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    do_read(8'h40, 1'b0, 1'b0, 1'b0, "R10 reset abort");
    chk("R10 word unchanged", {16'd0, rdata}, 32'h00001111);

    // Constrained random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [AW-1:0] a;
      logic [1:0] ln;
      op = $urandom_range(9);
      a  = AW'($urandom);
      ln = 2'($urandom_range(2));  // 0,1,2: never both lanes off
      if (op < 4)
        do_write(a, 16'($urandom), ln[0], ln[1], $urandom_range(1, 3), $urandom_range(2));
      else if (op < 8)
        do_read(a, ln[0], ln[1], 1'b0, "R3 random read");
      else if (op == 8)
        do_read(a, ln[0], ln[1], 1'b1, "R4 random oe high");
      else
        case ($urandom_range(2))
          0: do_standby(1'b1, 1'($urandom_range(1)), ln[0], ln[1]);
          1: do_standby(1'b0, 1'b0, ln[0], ln[1]);
          default: do_standby(1'b0, 1'b1, 1'b1, 1'b1);
        endcase
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule